// File: doc/BRIEF.md
# System Instruction Privilege Gate

This block sits beside the decode stage of a processor core that implements supervisor and hypervisor support. For five kinds of system instruction it decides whether the instruction may run under the current privilege state. The five kinds are wait-for-interrupt, the address-translation fence, the hypervisor translation fence, hypervisor virtual-machine loads and stores, and execute-permission hypervisor loads. The decision uses the privilege level, the virtualization flag, the trap-wait and trap-translation status bits, and the hypervisor user-access bit. For hypervisor memory accesses it also uses the requested access size.

For each valid request, one cycle later the block gives one verdict: allow or illegal-instruction. An allowed wait-for-interrupt also raises a one-cycle halt request. An allowed fence of either kind also raises a one-cycle TLB flush request. An allowed hypervisor access sets a two-stage translation enable. That enable stays high until the memory side reports the access as finished through `acc_done`.

Top module: `sysop_gate`

## Requirements
- R1: The verdict (`allow_o` or `illegal_o`, exactly one of them) appears in the cycle after a cycle with `req_valid` high. In a cycle after a cycle with `req_valid` low, `allow_o`, `illegal_o`, `halt_req` and `flush_req` are all low.
- R2: Wait-for-interrupt (kind bit 0) is illegal when the virtualization flag is set, or when the privilege is supervisor with trap-wait set. Otherwise it is allowed and `halt_req` pulses together with `allow_o`.
- R3: The address-translation fence (kind bit 1) is allowed in machine mode, and in supervisor mode with trap-translation clear. Otherwise it is illegal. When allowed, `flush_req` pulses together with `allow_o`.
- R4: The hypervisor fence (kind bit 2) is allowed in machine mode, and in supervisor mode with virtualization off. Otherwise it is illegal. When allowed, `flush_req` pulses.
- R5: A hypervisor load (kind bit 3), store (bit 4) or execute-permission load (bit 5) passes the privilege rule when any of these holds:
  - the privilege is machine;
  - the privilege is supervisor with virtualization off;
  - the privilege is user with virtualization off and the hypervisor user-access bit set.
- R6: Size codes are 0 signed byte, 1 unsigned byte, 2 signed halfword, 3 unsigned halfword, 4 signed word, 5 unsigned word, 6 doubleword, 7 unsupported. Loads and stores accept codes 0 to 6. Code 7 makes them illegal.
- R7: Execute-permission loads accept only size codes 3 and 5. Any other code makes them illegal.
- R8: `two_stage_en` rises in the same cycle as `allow_o` for an allowed hypervisor access. It stays high until the cycle after a cycle with `acc_done` high. An illegal access never raises it.
- R9: A valid request whose kind vector is not exactly one-hot is illegal, with no halt, flush or translation enable.
- R10: Privilege codes are user 0, supervisor 1 and machine 3. The reserved code 2 is treated as user.
- R11: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_kind | input | 6 | One-hot instruction kind (bit 0 wait, 1 translation fence, 2 hypervisor fence, 3 hyp load, 4 hyp store, 5 hyp execute load) |
| cur_priv | input | 2 | Current privilege level |
| virt_on | input | 1 | Virtualization flag |
| trap_wait | input | 1 | Status bit trapping wait-for-interrupt in supervisor mode |
| trap_vm | input | 1 | Status bit trapping translation fences in supervisor mode |
| hyp_user | input | 1 | Hypervisor access from user mode permitted |
| acc_size | input | 3 | Access size code for hypervisor accesses |
| acc_done | input | 1 | Memory side finished the current hypervisor access |
| allow_o | output | 1 | Request allowed |
| illegal_o | output | 1 | Illegal-instruction verdict |
| halt_req | output | 1 | One-cycle halt request |
| flush_req | output | 1 | One-cycle TLB flush request |
| two_stage_en | output | 1 | Two-stage translation enable |

## Verification
Every verdict, halt pulse, flush pulse and the rising edge of `two_stage_en` is due one clock edge after the request cycle. The bench drives each request on a falling edge, drops `req_valid` on the next falling edge, and samples all five outputs at that point, after the single register stage has updated. The fall of `two_stage_en` is due one edge after `acc_done` is seen. The bench raises `acc_done` on a falling edge and checks the enable on the next falling edge. It also checks the enable across idle cycles while `acc_done` is held low.

// File: rtl/sysop_pkg.sv
package sysop_pkg;
  localparam int KIND_W = 6;
  localparam int SIZE_W = 3;
  localparam int PRIV_W = 2;

  // Kind vector bit positions (decoded by the neighbouring decode stage)
  localparam int K_WAIT    = 0;
  localparam int K_VMFENCE = 1;
  localparam int K_HVFENCE = 2;
  localparam int K_HLOAD   = 3;
  localparam int K_HSTORE  = 4;
  localparam int K_HXLOAD  = 5;

  typedef enum logic [PRIV_W-1:0] {
    LVL_USER = 2'd0,
    LVL_SUP  = 2'd1,
    LVL_RSVD = 2'd2,
    LVL_MACH = 2'd3
  } level_e;

  // Access size codes
  localparam logic [SIZE_W-1:0] SZ_UHALF = 3'd3;
  localparam logic [SIZE_W-1:0] SZ_UWORD = 3'd5;
  localparam logic [SIZE_W-1:0] SZ_BAD   = 3'd7;

  typedef struct packed {
    logic ok;
    logic halt;
    logic flush;
    logic xlate;
  } verdict_t;

  // Reserved level folds onto user
  function automatic level_e norm_level(logic [PRIV_W-1:0] p);
    level_e l;
    case (p)
      2'd1:    l = LVL_SUP;
      2'd3:    l = LVL_MACH;
      default: l = LVL_USER;
    endcase
    return l;
  endfunction

  function automatic logic size_ok_plain(logic [SIZE_W-1:0] s);
    return s != SZ_BAD;
  endfunction

  function automatic logic size_ok_exec(logic [SIZE_W-1:0] s);
    return (s == SZ_UHALF) || (s == SZ_UWORD);
  endfunction
endpackage

// File: rtl/sysop_size_chk.sv
module sysop_size_chk
  import sysop_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  input  logic [SIZE_W-1:0] size,
  output logic              size_ok
);
  logic plain_ok;
  logic exec_ok;

  always_comb begin
    plain_ok = size_ok_plain(size);
    exec_ok  = size_ok_exec(size);
  end

  // Only hypervisor accesses carry a size; other kinds pass
  always_comb begin
    if (kind[K_HXLOAD])
      size_ok = exec_ok;
    else if (kind[K_HLOAD] || kind[K_HSTORE])
      size_ok = plain_ok;
    else
      size_ok = 1'b1;
  end
endmodule

// File: rtl/sysop_rules.sv
module sysop_rules
  import sysop_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  input  logic [PRIV_W-1:0] priv,
  input  logic              virt,
  input  logic              tw,
  input  logic              tvm,
  input  logic              hu,
  input  logic              size_ok,
  output verdict_t          verdict,
  output logic              kind_onehot
);
  level_e lvl;
  logic   in_m, in_s, in_u;
  logic   wait_ok, vmf_ok, hvf_ok, hacc_ok;
  logic   is_hacc;

  always_comb begin
    lvl  = norm_level(priv);
    in_m = (lvl == LVL_MACH);
    in_s = (lvl == LVL_SUP);
    in_u = (lvl == LVL_USER);
  end

  // Per-kind privilege rules
  always_comb begin
    wait_ok = !virt && !(in_s && tw);
    vmf_ok  = in_m || (in_s && !tvm);
    hvf_ok  = in_m || (in_s && !virt);
    hacc_ok = in_m || (in_s && !virt) || (in_u && !virt && hu);
  end

  always_comb begin
    kind_onehot = $onehot(kind);
    is_hacc     = kind[K_HLOAD] || kind[K_HSTORE] || kind[K_HXLOAD];
  end

  always_comb begin
    verdict = '0;
    if (kind_onehot) begin
      if (kind[K_WAIT]) begin
        verdict.ok   = wait_ok;
        verdict.halt = wait_ok;
      end else if (kind[K_VMFENCE]) begin
        verdict.ok    = vmf_ok;
        verdict.flush = vmf_ok;
      end else if (kind[K_HVFENCE]) begin
        verdict.ok    = hvf_ok;
        verdict.flush = hvf_ok;
      end else if (is_hacc) begin
        verdict.ok    = hacc_ok && size_ok;
        verdict.xlate = hacc_ok && size_ok;
      end
    end
  end

  always_comb begin
    if (verdict.halt)  assert (kind[K_WAIT]) else $error("p_halt_kind_r2");
    if (verdict.xlate) assert (is_hacc)      else $error("p_xlate_kind_r8");
  end
endmodule

// File: rtl/sysop_xlate_hold.sv
module sysop_xlate_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  input  logic done,
  output logic en
);
  logic en_q;
  logic en_d;

  // A new grant wins over a completion seen in the same cycle
  always_comb en_d = grant | (en_q & ~done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign en = en_q;
endmodule

// File: rtl/sysop_gate.sv
module sysop_gate
  import sysop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [KIND_W-1:0] req_kind,
  input  logic [PRIV_W-1:0] cur_priv,
  input  logic              virt_on,
  input  logic              trap_wait,
  input  logic              trap_vm,
  input  logic              hyp_user,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic              acc_done,
  output logic              allow_o,
  output logic              illegal_o,
  output logic              halt_req,
  output logic              flush_req,
  output logic              two_stage_en
);
  logic     size_ok;
  logic     kind_onehot;
  verdict_t verdict;
  logic     xlate_grant;

  sysop_size_chk u_size (
    .kind    (req_kind),
    .size    (acc_size),
    .size_ok (size_ok)
  );

  sysop_rules u_rules (
    .kind        (req_kind),
    .priv        (cur_priv),
    .virt        (virt_on),
    .tw          (trap_wait),
    .tvm         (trap_vm),
    .hu          (hyp_user),
    .size_ok     (size_ok),
    .verdict     (verdict),
    .kind_onehot (kind_onehot)
  );

  always_comb xlate_grant = req_valid && verdict.xlate;

  sysop_xlate_hold u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .grant (xlate_grant),
    .done  (acc_done),
    .en    (two_stage_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      allow_o   <= 1'b0;
      illegal_o <= 1'b0;
      halt_req  <= 1'b0;
      flush_req <= 1'b0;
    end else begin
      allow_o   <= req_valid && verdict.ok;
      illegal_o <= req_valid && !verdict.ok;
      halt_req  <= req_valid && verdict.halt;
      flush_req <= req_valid && verdict.flush;
    end
  end

  always_comb begin
    if (!kind_onehot) assert (!verdict.ok) else $error("p_bad_kind_r9");
  end

  p_one_verdict_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (allow_o ^ illegal_o));
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(allow_o || illegal_o || halt_req || flush_req));
  p_halt_allowed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> allow_o);
  p_flush_allowed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> allow_o && !halt_req);
  p_xlate_from_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(two_stage_en) |-> $past(req_valid && (req_kind[K_HLOAD] || req_kind[K_HSTORE] || req_kind[K_HXLOAD])));
  p_rise_with_allow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(two_stage_en) |-> allow_o);
  p_fall_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(two_stage_en) |-> $past(acc_done));
endmodule

// File: tb/sysop_gate_test.sv
`timescale 1ns/1ps
module sysop_gate_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [5:0] req_kind = '0;
  logic [1:0] cur_priv = '0;
  logic       virt_on = 1'b0, trap_wait = 1'b0, trap_vm = 1'b0, hyp_user = 1'b0;
  logic [2:0] acc_size = '0;
  logic       acc_done = 1'b1;
  logic       allow_o, illegal_o, halt_req, flush_req, two_stage_en;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sysop_gate uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .cur_priv(cur_priv), .virt_on(virt_on), .trap_wait(trap_wait),
    .trap_vm(trap_vm), .hyp_user(hyp_user), .acc_size(acc_size),
    .acc_done(acc_done), .allow_o(allow_o), .illegal_o(illegal_o),
    .halt_req(halt_req), .flush_req(flush_req), .two_stage_en(two_stage_en)
  );

  // Expected {allow, illegal, halt, flush, xlate} from the requirements
  function automatic logic [4:0] model(int k, int p, bit v, bit b, int sz);
    int  lv;
    bit  ok;
    bit  h;
    bit  f;
    bit  x;
    h = 0; f = 0; x = 0;
    lv = (p == 2) ? 0 : p;                    // R10
    case (k)
      0: begin ok = !(v || (lv == 1 && b)); h = ok; end          // R2
      1: begin ok = (lv == 3) || (lv == 1 && !b); f = ok; end     // R3
      2: begin ok = (lv == 3) || (lv == 1 && !v); f = ok; end     // R4
      default: begin                                              // R5
        ok = (lv == 3) || (!v && lv == 1) || (!v && lv == 0 && b);
        if (k == 5) ok = ok && (sz == 3 || sz == 5);              // R7
        else        ok = ok && (sz < 7);                          // R6
        x = ok;
      end
    endcase
    return {ok, !ok, h, f, x};
  endfunction

  task automatic check(string tag, logic [4:0] got, logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got {allow,illegal,halt,flush,xlate}=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic issue(logic [5:0] kv, int p, bit v, bit b, int sz);
    @(negedge clk);
    req_valid = 1'b1; req_kind = kv; cur_priv = 2'(p); virt_on = v;
    trap_wait = b; trap_vm = b; hyp_user = b; acc_size = 3'(sz);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [4:0] outs();
    return {allow_o, illegal_o, halt_req, flush_req, two_stage_en};
  endfunction

  task automatic sweep_kind(int k, string tag);
    for (int p = 0; p < 4; p++)
      for (int v = 0; v < 2; v++)
        for (int b = 0; b < 2; b++)
          for (int si = 0; si < 5; si++) begin
            int sz;
            sz = (si == 0) ? 0 : (si == 1) ? 3 : (si == 2) ? 5 : (si == 3) ? 6 : 7;
            if (k < 3 && si > 0) continue;
            issue(6'(1 << k), p, v[0], b[0], sz);
            check(tag, outs(), model(k, p, v[0], b[0], sz));
          end
  endtask

  task automatic t_reset();
    check("R11 reset", outs(), 5'b0);
  endtask

  task automatic t_wait();    sweep_kind(0, "R2 wait");           endtask
  task automatic t_vmfence(); sweep_kind(1, "R3 vm fence");       endtask
  task automatic t_hvfence(); sweep_kind(2, "R4 hyp fence");      endtask
  task automatic t_hload();   sweep_kind(3, "R5/R6 hyp load");    endtask
  task automatic t_hstore();  sweep_kind(4, "R5/R6 hyp store");   endtask
  task automatic t_hxload();  sweep_kind(5, "R7 hyp exec load");  endtask

  task automatic t_sizes();
    for (int sz = 0; sz < 8; sz++) begin
      issue(6'b001000, 3, 1'b0, 1'b0, sz);
      check("R6 load size", outs(), model(3, 3, 0, 0, sz));
      issue(6'b100000, 3, 1'b0, 1'b0, sz);
      check("R7 exec size", outs(), model(5, 3, 0, 0, sz));
    end
  endtask

  task automatic t_reserved_level();
    issue(6'b000001, 2, 1'b0, 1'b1, 0);
    check("R10 wait at level 2", outs(), 5'b10100);
    issue(6'b000010, 2, 1'b0, 1'b0, 0);
    check("R10 fence at level 2", outs(), 5'b01000);
    issue(6'b010000, 2, 1'b0, 1'b1, 4);
    check("R10 store at level 2 hu", outs(), 5'b10001);
  endtask

  task automatic t_bad_kind();
    issue(6'b000000, 3, 1'b0, 1'b0, 0);
    check("R9 empty kind", outs(), 5'b01000);
    issue(6'b000011, 3, 1'b0, 1'b0, 0);
    check("R9 two kinds", outs(), 5'b01000);
    issue(6'b101000, 3, 1'b0, 1'b0, 3);
    check("R9 two access kinds", outs(), 5'b01000);
  endtask

  task automatic t_idle();
    @(negedge clk);
    repeat (3) begin
      @(negedge clk);
      check("R1 idle", outs(), 5'b0);
    end
  endtask

  task automatic t_two_stage();
    acc_done = 1'b0;
    issue(6'b001000, 1, 1'b0, 1'b0, 6);
    check("R8 rise with allow", outs(), 5'b10001);
    repeat (3) begin
      @(negedge clk);
      check("R8 hold while busy", outs(), 5'b00001);
    end
    acc_done = 1'b1;
    @(negedge clk);
    acc_done = 1'b0;
    check("R8 drop after done", outs(), 5'b0);
    issue(6'b010000, 0, 1'b0, 1'b0, 2);
    check("R8 illegal keeps low", outs(), 5'b01000);
    @(negedge clk);
    check("R8 still low", outs(), 5'b0);
    issue(6'b100000, 3, 1'b1, 1'b0, 5);
    check("R8 exec rise", outs(), 5'b10001);
    acc_done = 1'b1;
    @(negedge clk);
    check("R8 exec drop", outs(), 5'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wait();
    t_vmfence();
    t_hvfence();
    t_hload();
    t_hstore();
    t_hxload();
    t_sizes();
    t_reserved_level();
    t_bad_kind();
    t_idle();
    t_two_stage();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule